// File: doc/BRIEF.md
# Breakpoint Ignore-First-Match Gate

This block sits between the instruction-fetch breakpoint comparators and the instruction breakpoint request line. A debugger that has stopped the processor at a breakpoint can resume from that same address. It sets a software-owned skip bit, and the block then swallows the first comparator match that follows the next enable event. Without that skip the processor would stop again at once on the instruction it was resumed at. After the one suppressed match, hardware clears the skip bit. With the skip bit clear, every match raises a request. Matches that come from the match counters always reach the output and never consume the skip.

An enable event happens in two cases. One is the first software write to the control register after reset. The other is a 0-to-1 transition of the recoverable-state flag while masked mode is selected. The request output is a registered single-cycle pulse per qualifying match.

Top module: `bkpt_skip_gate`

## Requirements
- R1: Synchronous active-high reset drives `brk_req` and `skip_bit` to 0 and leaves no enable event pending, so a valid match after reset produces a request.
- R2: A control write (`ctl_wr_en`=1) makes `skip_bit` read back the written value `ctl_wr_skip` in the cycle after the write.
- R3: The first control write after reset is an enable event. If the resulting skip bit is 1, the first valid non-counter match in a later cycle produces no request.
- R4: A 0-to-1 transition of `recov_flag` while `masked_sel`=1 is an enable event. A flag that stays at 1 is not an event. A rise with `masked_sel`=0 is not an event.
- R5: When a match is suppressed, `skip_bit` reads 0 from the next cycle, and later matches produce requests.
- R6: While the skip bit is 0, every valid match produces a request.
- R7: A valid match with `cmp_from_cnt`=1 always produces a request and does not consume the pending skip.
- R8: If a control write and a hardware clear fall in the same cycle, the written value wins.
- R9: `brk_req` is 1 in the single cycle after a cycle with `fetch_valid`=1 and `cmp_hit`=1 that is not suppressed. It is 0 after any other cycle, including a `cmp_hit` without `fetch_valid`.
- R10: Control writes after the first one are not enable events. Setting the skip bit with a later write does not suppress the next match.
- R11: A match in the same cycle as an enable event is not suppressed. Only matches in later cycles are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Instruction-valid strobe for the current fetch |
| cmp_hit | input | 1 | Address comparator match for the current fetch |
| cmp_from_cnt | input | 1 | Match was generated by a match counter |
| ctl_wr_en | input | 1 | Software write strobe for the control register |
| ctl_wr_skip | input | 1 | Skip bit value carried by the write |
| recov_flag | input | 1 | Recoverable-state flag of the processor |
| masked_sel | input | 1 | Masked mode selected |
| brk_req | output | 1 | Registered instruction breakpoint request pulse |
| skip_bit | output | 1 | Readable skip (ignore-first-match) bit |

## Verification
Both outputs are registered, so each is due exactly one clock edge after the inputs that cause it. The request reflects the match of the previous cycle. The skip bit reflects the write or suppression of the previous cycle. An enable event only takes effect for matches in cycles after it. The bench applies each cycle's inputs at a falling edge and compares both outputs at the next falling edge against a reference model stepped once per cycle. Directed sequences cover write/clear collisions, level versus edge on the recoverable flag, and counter matches. A seeded random run follows.

// File: rtl/bkpt_skip_pkg.sv
package bkpt_skip_pkg;

    typedef struct packed {
        logic hit;       // valid fetch with comparator match
        logic from_cnt;  // match produced by a counter
    } fetch_hit_t;

    typedef struct packed {
        logic wr;
        logic data;
    } ctl_wr_t;

    function automatic logic skippable(fetch_hit_t h);
        return h.hit && !h.from_cnt;
    endfunction

endpackage

// File: rtl/bkpt_rise_detect.sv
module bkpt_rise_detect (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level;
    end

    assign rise = level && !level_q;
endmodule

// File: rtl/bkpt_skip_ctrl.sv
module bkpt_skip_ctrl
    import bkpt_skip_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fetch_hit_t hit,
    input  ctl_wr_t    wr,
    input  logic       hw_enable,
    output logic       skip_bit,
    output logic       suppress
);
    logic skip_q, pend_q, wr_seen_q;
    logic skip_n, pend_n, enable_evt;

    assign suppress   = skippable(hit) && pend_q && skip_q;
    assign enable_evt = (wr.wr && !wr_seen_q) || hw_enable;

    always_comb begin
        if (wr.wr)         skip_n = wr.data;
        else if (suppress) skip_n = 1'b0;
        else               skip_n = skip_q;

        if (enable_evt)    pend_n = skip_n;
        else if (suppress) pend_n = 1'b0;
        else               pend_n = pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            skip_q    <= 1'b0;
            pend_q    <= 1'b0;
            wr_seen_q <= 1'b0;
        end else begin
            skip_q    <= skip_n;
            pend_q    <= pend_n;
            wr_seen_q <= wr_seen_q | wr.wr;
        end
    end

    assign skip_bit = skip_q;
endmodule

// File: rtl/bkpt_req_stage.sv
module bkpt_req_stage
    import bkpt_skip_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fetch_hit_t hit,
    input  logic       suppress,
    output logic       req
);
    always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= hit.hit && !suppress;
    end
endmodule

// File: rtl/bkpt_skip_gate.sv
module bkpt_skip_gate
    import bkpt_skip_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fetch_valid,
    input  logic cmp_hit,
    input  logic cmp_from_cnt,
    input  logic ctl_wr_en,
    input  logic ctl_wr_skip,
    input  logic recov_flag,
    input  logic masked_sel,
    output logic brk_req,
    output logic skip_bit
);
    fetch_hit_t hit;
    ctl_wr_t    wr;
    logic       recov_rise, suppress;

    assign hit.hit      = fetch_valid && cmp_hit;
    assign hit.from_cnt = cmp_from_cnt;
    assign wr.wr        = ctl_wr_en;
    assign wr.data      = ctl_wr_skip;

    bkpt_rise_detect u_rise (
        .clk   (clk),
        .rst   (rst),
        .level (recov_flag),
        .rise  (recov_rise)
    );

    bkpt_skip_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .wr        (wr),
        .hw_enable (recov_rise && masked_sel),
        .skip_bit  (skip_bit),
        .suppress  (suppress)
    );

    bkpt_req_stage u_req (
        .clk      (clk),
        .rst      (rst),
        .hit      (hit),
        .suppress (suppress),
        .req      (brk_req)
    );
endmodule

// File: rtl/bkpt_skip_gate_chk.sv
module bkpt_skip_gate_chk (
    input logic clk,
    input logic rst,
    input logic fetch_valid,
    input logic cmp_hit,
    input logic cmp_from_cnt,
    input logic ctl_wr_en,
    input logic ctl_wr_skip,
    input logic brk_req,
    input logic skip_bit
);
    p_req_needs_hit_r9: assert property (@(posedge clk) disable iff (rst)
        brk_req |-> $past(fetch_valid && cmp_hit));

    p_write_readback_r2: assert property (@(posedge clk) disable iff (rst)
        ctl_wr_en |=> (skip_bit == $past(ctl_wr_skip)));

    p_counter_pass_r7: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && cmp_hit && cmp_from_cnt) |=> brk_req);

    p_clear_bit_pass_r6: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && cmp_hit && !skip_bit && !ctl_wr_en) |=> brk_req);

    p_hw_clear_swallows_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(skip_bit) && !$past(ctl_wr_en)) |-> !brk_req);

    p_only_sw_sets_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(skip_bit) |-> $past(ctl_wr_en));
endmodule

bind bkpt_skip_gate bkpt_skip_gate_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .fetch_valid  (fetch_valid),
    .cmp_hit      (cmp_hit),
    .cmp_from_cnt (cmp_from_cnt),
    .ctl_wr_en    (ctl_wr_en),
    .ctl_wr_skip  (ctl_wr_skip),
    .brk_req      (brk_req),
    .skip_bit     (skip_bit)
);

// File: tb/bkpt_skip_gate_bench.sv
module bkpt_skip_gate_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fetch_valid = 0, cmp_hit = 0, cmp_from_cnt = 0;
    logic ctl_wr_en = 0, ctl_wr_skip = 0, recov_flag = 0, masked_sel = 0;
    logic brk_req, skip_bit;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    // reference state
    bit m_skip = 0, m_pend = 0, m_wrseen = 0, m_recq = 0;

    always #4 clk = ~clk;

    bkpt_skip_gate u_bkpt_skip_gate (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .cmp_hit(cmp_hit),
        .cmp_from_cnt(cmp_from_cnt), .ctl_wr_en(ctl_wr_en), .ctl_wr_skip(ctl_wr_skip),
        .recov_flag(recov_flag), .masked_sel(masked_sel),
        .brk_req(brk_req), .skip_bit(skip_bit)
    );

    function automatic bit exp_req(bit fv, bit h, bit cnt);
        return fv && h && !(!cnt && m_pend && m_skip);
    endfunction

    task automatic check(string tag, string what, bit act, bit exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    // drive one cycle at a falling edge, check outputs at the next falling edge
    task automatic step(string tag, bit fv, bit h, bit cnt, bit we, bit wd, bit rec, bit msk);
        bit e_req, sup, ev, s_n;
        fetch_valid = fv; cmp_hit = h; cmp_from_cnt = cnt;
        ctl_wr_en = we; ctl_wr_skip = wd; recov_flag = rec; masked_sel = msk;
        e_req = exp_req(fv, h, cnt);
        sup   = fv && h && !cnt && m_pend && m_skip;
        ev    = (we && !m_wrseen) || (rec && !m_recq && msk);
        s_n   = we ? wd : (sup ? 1'b0 : m_skip);
        m_pend   = ev ? s_n : (sup ? 1'b0 : m_pend);
        m_skip   = s_n;
        m_wrseen = m_wrseen | we;
        m_recq   = rec;
        @(negedge clk);
        check(tag, "brk_req", brk_req, e_req);
        check(tag, "skip_bit", skip_bit, m_skip);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", "reset brk_req", brk_req, 1'b0);
        check("R1", "reset skip_bit", skip_bit, 1'b0);
        step("R1 R6", 1,1,0, 0,0, 0,0);   // no enable yet: request
        step("R9",    0,1,0, 0,0, 0,0);   // no fetch_valid: nothing
        step("R11 R2",1,1,0, 1,1, 0,0);   // first write + same-cycle match
        step("R9",    0,0,0, 0,0, 0,0);   // pulse ends
        step("R7",    1,1,1, 0,0, 0,0);   // counter match passes, keeps skip
        step("R3 R5", 1,1,0, 0,0, 0,0);   // swallowed, bit cleared
        step("R5",    1,1,0, 0,0, 0,0);   // next match passes
        step("R2",    0,0,0, 1,1, 0,0);   // later write sets bit
        step("R10",   1,1,0, 0,0, 0,0);   // not an enable event
        step("R4",    0,0,0, 0,0, 1,1);   // rise in masked mode
        step("R8 R4", 1,1,0, 1,1, 1,1);   // suppress + write: write wins
        step("R4",    1,1,0, 0,0, 1,1);   // held level: no new event
        step("R4",    0,0,0, 0,0, 0,0);
        step("R4",    0,0,0, 0,0, 1,0);   // rise, not masked
        step("R4",    1,1,0, 0,0, 1,0);
        step("R6",    0,0,0, 1,0, 0,0);
        step("R6",    1,1,0, 0,0, 0,0);
        for (int i = 0; i < 3000; i++) begin
            bit we;
            we = ($urandom % 10) == 0;
            step("R3 R4 R6 R7 R9", ($urandom % 4) != 0, $urandom % 2, ($urandom % 5) == 0,
                 we, $urandom % 2, ($urandom % 3) != 0, $urandom % 2);
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule